// File: doc/BRIEF.md
# Ternary Sign-Update Crossbar Controller

This block is the digital side of on-chip training for one fully connected layer held in a resistive crossbar. At the start of a training iteration it captures one signed error word per output column, one binary forward bit per row and a threshold. It reduces each column error to a ternary sign. An error at or above the threshold in magnitude keeps its sign; any other error becomes zero. The block keeps the ternary sign of each column from the previous iteration. A column may program its cells only when its new sign is nonzero and matches that stored sign.

After capture the block walks the array one cell per cycle in row-major order. The update term of a cell is the gated column sign multiplied by the row bit. A positive term asks for one conductance-raising pulse, a negative term asks for one conductance-lowering pulse, and a zero term asks for nothing. The block offers each pulse request on a valid/ready command port. It raises a one-cycle done flag after the last cell and reports how many pulses the iteration issued.

Top module: `sign_update_ctrl`

## Requirements
- R1: A column's ternary sign is +1 or -1 (the sign of its error) when the error is nonzero and its magnitude is at least the threshold, and 0 otherwise. Errors and threshold are two's complement, EW bits wide.
- R2: The most negative error counts as having the largest positive magnitude, 2^(EW-1)-1. A negative threshold acts as zero. A threshold of zero lets every nonzero error through.
- R3: The update term of cell (row, column) is the gated column sign times the row's forward bit. A row whose forward bit is 0 issues no command.
- R4: Each nonzero update term issues exactly one command. The op code is 2'b01 for a +1 term (raise) and 2'b10 for a -1 term (lower). Code 2'b00 never appears with cmd_valid high.
- R5: A column issues commands only when its new sign is nonzero and equals the sign stored from the previous iteration. The first iteration after reset issues no commands.
- R6: At the end of every iteration, each column's stored sign becomes the new ternary sign, whether or not the column issued any command.
- R7: mom_clr sets every stored sign to 0 when it is asserted while the block is idle. It has no effect while an iteration is running.
- R8: Commands appear in row-major order (row outer, column inner), with strictly increasing cell index, one cell visited per cycle. Cells with a zero term are skipped. While cmd_ready is low, an offered command holds row, column and op unchanged.
- R9: done is high for exactly one cycle, in the cycle after the last cell has been handled. busy is low in that cycle.
- R10: pulse_count is cleared when an iteration starts and counts the accepted commands. It holds its final value until the next start.
- R11: start is accepted only while busy is low. err_flat, fwd_bits and sigma are captured at acceptance, and later changes to them, or a start pulse during the scan, do not alter the iteration in progress.
- R12: After reset, busy, done, cmd_valid and pulse_count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an iteration (accepted while idle) |
| mom_clr | input | 1 | Clear all stored column signs (honoured while idle) |
| err_flat | input | COLS*EW | Column errors, column c in bits [c*EW +: EW], two's complement |
| fwd_bits | input | ROWS | Binary forward input, one bit per row |
| sigma | input | EW | Quantization threshold, two's complement |
| cmd_ready | input | 1 | Downstream pulse driver accepts the offered command |
| cmd_valid | output | 1 | A pulse command is offered |
| cmd_row | output | clog2(ROWS) | Row of the offered command |
| cmd_col | output | clog2(COLS) | Column of the offered command |
| cmd_op | output | 2 | 2'b01 raise, 2'b10 lower |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle end-of-iteration flag |
| pulse_count | output | clog2(ROWS*COLS+1) | Commands accepted in the current or last iteration |

## Verification
The properties assume that start, mom_clr and cmd_ready are synchronous to clk and that cmd_ready may change in any cycle. The bench drives all inputs on the falling edge. It switches cmd_ready among always-high, pseudo-random and sparse patterns, so that the hold and ordering properties see real back-pressure. The data inputs matter only at acceptance, so the bench changes fwd_bits and pulses start and mom_clr in the middle of some scans to show that nothing leaks in. Error and threshold values cover every EW-bit error, including the most negative one, against several thresholds, including zero and a negative value.

// File: rtl/sgu_pkg.sv
package sgu_pkg;

  // ternary sign encoding used between quantizers, momentum bank and scanner
  typedef enum logic [1:0] {
    TRI_ZERO = 2'b00,
    TRI_POS  = 2'b01,
    TRI_NEG  = 2'b11
  } tri_t;

  // pulse command op codes seen at the command port
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_SET   = 2'b01,
    OP_RESET = 2'b10
  } op_t;

endpackage

// File: rtl/sgu_quant.sv
module sgu_quant
  import sgu_pkg::*;
#(
  parameter int EW = 8
) (
  input  logic [EW-1:0] err_i,
  input  logic [EW-1:0] thr_i,
  output logic [1:0]    sgn_o
);

  localparam logic [EW-1:0] MOST_NEG = {1'b1, {(EW-1){1'b0}}};
  localparam logic [EW-1:0] MAX_MAG  = {1'b0, {(EW-1){1'b1}}};

  logic          neg;
  logic [EW-1:0] mag;
  logic [EW-1:0] thr_eff;

  always_comb begin
    neg = err_i[EW-1];
    if (!neg)                  mag = err_i;
    else if (err_i == MOST_NEG) mag = MAX_MAG;   // R2 saturate
    else                       mag = -err_i;
    thr_eff = thr_i[EW-1] ? '0 : thr_i;           // R2 negative threshold acts as zero
    if (err_i == '0)           sgn_o = TRI_ZERO;
    else if (mag >= thr_eff)   sgn_o = neg ? TRI_NEG : TRI_POS;  // R1
    else                       sgn_o = TRI_ZERO;
  end

endmodule

// File: rtl/sgu_momentum.sv
module sgu_momentum
  import sgu_pkg::*;
#(
  parameter int COLS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [2*COLS-1:0] cur_i,
  output logic [2*COLS-1:0] gate_o
);

  logic [2*COLS-1:0] mom_q;
  logic [2*COLS-1:0] mom_n;
  logic              mom_en;

  always_comb begin
    mom_en = clr_i | cap_i;
    if (clr_i)      mom_n = '0;     // R7
    else            mom_n = cur_i;  // R6
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mom_q <= '0;
    else if (mom_en) mom_q <= mom_n;
  end

  // R5: a column passes its sign only on agreement with a nonzero stored sign
  for (genvar c = 0; c < COLS; c++) begin : g_gate
    logic [1:0] cur_c;
    logic [1:0] old_c;
    assign cur_c = cur_i[2*c +: 2];
    assign old_c = mom_q[2*c +: 2];
    assign gate_o[2*c +: 2] = ((cur_c == old_c) && (cur_c != TRI_ZERO)) ? cur_c : TRI_ZERO;
  end

endmodule

// File: rtl/sgu_scan.sv
module sgu_scan
  import sgu_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start_i,
  input  logic [2*COLS-1:0]                      gate_i,
  input  logic [ROWS-1:0]                        fwd_i,
  input  logic                                   ready_i,
  output logic                                   valid_o,
  output logic [((ROWS>1)?$clog2(ROWS):1)-1:0]   row_o,
  output logic [((COLS>1)?$clog2(COLS):1)-1:0]   col_o,
  output logic [1:0]                             op_o,
  output logic                                   busy_o,
  output logic                                   done_o,
  output logic                                   finish_o,
  output logic [$clog2(ROWS*COLS+1)-1:0]         count_o
);

  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int PCW = $clog2(ROWS*COLS+1);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS-1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS-1);

  logic           busy_q, busy_n;
  logic           done_q, done_n;
  logic [RW-1:0]  row_q, row_n;
  logic [CW-1:0]  col_q, col_n;
  logic [PCW-1:0] cnt_q, cnt_n;
  logic           st_en;

  logic [1:0] cur_sgn;
  logic       act, fire, adv, last;

  always_comb begin
    cur_sgn = gate_i[2*col_q +: 2];
    act     = busy_q && fwd_i[row_q] && (cur_sgn != TRI_ZERO);   // R3
    fire    = act && ready_i;
    adv     = busy_q && (!act || ready_i);                        // R8 stall
    last    = (row_q == ROW_LAST) && (col_q == COL_LAST);
  end

  always_comb begin
    busy_n = busy_q;
    row_n  = row_q;
    col_n  = col_q;
    cnt_n  = cnt_q + PCW'(fire);
    if (start_i && !busy_q) begin          // R11
      busy_n = 1'b1;
      row_n  = '0;
      col_n  = '0;
      cnt_n  = '0;
    end else if (adv) begin
      if (last) begin
        busy_n = 1'b0;
      end else if (col_q == COL_LAST) begin
        col_n = '0;
        row_n = row_q + 1'b1;
      end else begin
        col_n = col_q + 1'b1;
      end
    end
    done_n = adv && last;                  // R9
    st_en  = start_i | busy_q | done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      cnt_q  <= '0;
    end else if (st_en) begin
      busy_q <= busy_n;
      done_q <= done_n;
      row_q  <= row_n;
      col_q  <= col_n;
      cnt_q  <= cnt_n;
    end
  end

  assign valid_o  = act;
  assign row_o    = row_q;
  assign col_o    = col_q;
  assign op_o     = act ? ((cur_sgn == TRI_POS) ? OP_SET : OP_RESET) : OP_NONE;  // R4
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign finish_o = adv && last;
  assign count_o  = cnt_q;

endmodule

// File: rtl/sign_update_ctrl.sv
module sign_update_ctrl
  import sgu_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int EW   = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic                                 mom_clr,
  input  logic [COLS*EW-1:0]                   err_flat,
  input  logic [ROWS-1:0]                      fwd_bits,
  input  logic [EW-1:0]                        sigma,
  input  logic                                 cmd_ready,
  output logic                                 cmd_valid,
  output logic [((ROWS>1)?$clog2(ROWS):1)-1:0] cmd_row,
  output logic [((COLS>1)?$clog2(COLS):1)-1:0] cmd_col,
  output logic [1:0]                           cmd_op,
  output logic                                 busy,
  output logic                                 done,
  output logic [$clog2(ROWS*COLS+1)-1:0]       pulse_count
);

  logic [1:0] rs_q;
  logic       rst_int_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic [COLS*EW-1:0] err_q;
  logic [ROWS-1:0]    fwd_q;
  logic [EW-1:0]      sig_q;
  logic               accept;
  logic               finish;
  logic [2*COLS-1:0]  cur_sgn;
  logic [2*COLS-1:0]  gate_sgn;

  assign accept = start & ~busy;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      err_q <= '0;
      fwd_q <= '0;
      sig_q <= '0;
    end else if (accept) begin
      err_q <= err_flat;
      fwd_q <= fwd_bits;
      sig_q <= sigma;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    sgu_quant #(.EW(EW)) u_quant (
      .err_i (err_q[c*EW +: EW]),
      .thr_i (sig_q),
      .sgn_o (cur_sgn[2*c +: 2])
    );
  end

  sgu_momentum #(.COLS(COLS)) u_mom (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (mom_clr & ~busy),
    .cap_i  (finish),
    .cur_i  (cur_sgn),
    .gate_o (gate_sgn)
  );

  sgu_scan #(.ROWS(ROWS), .COLS(COLS)) u_scan (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start),
    .gate_i   (gate_sgn),
    .fwd_i    (fwd_q),
    .ready_i  (cmd_ready),
    .valid_o  (cmd_valid),
    .row_o    (cmd_row),
    .col_o    (cmd_col),
    .op_o     (cmd_op),
    .busy_o   (busy),
    .done_o   (done),
    .finish_o (finish),
    .count_o  (pulse_count)
  );

endmodule

// File: rtl/sgu_chk.sv
module sgu_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 cmd_valid,
  input logic                                 cmd_ready,
  input logic [((ROWS>1)?$clog2(ROWS):1)-1:0] cmd_row,
  input logic [((COLS>1)?$clog2(COLS):1)-1:0] cmd_col,
  input logic [1:0]                           cmd_op,
  input logic                                 busy,
  input logic                                 done,
  input logic [$clog2(ROWS*COLS+1)-1:0]       pulse_count
);

  logic fire;
  int   cur_idx;
  int   last_idx;
  logic have_q;

  always_comb begin
    fire    = cmd_valid && cmd_ready;
    cur_idx = int'(cmd_row) * COLS + int'(cmd_col);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q   <= 1'b0;
      last_idx <= 0;
    end else if (done) begin
      have_q   <= 1'b0;
    end else if (fire) begin
      have_q   <= 1'b1;
      last_idx <= cur_idx;
    end
  end

  assert_op_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op == 2'b01 || cmd_op == 2'b10));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_row) && $stable(cmd_col) && $stable(cmd_op)));

  assert_row_major_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && have_q) |-> (cur_idx > last_idx));

  assert_valid_in_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fire) |=> (pulse_count == $past(pulse_count) + 1'b1));

  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire) |=> $stable(pulse_count));

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pulse_count) <= ROWS * COLS);

endmodule

bind sign_update_ctrl sgu_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_row     (cmd_row),
  .cmd_col     (cmd_col),
  .cmd_op      (cmd_op),
  .busy        (busy),
  .done        (done),
  .pulse_count (pulse_count)
);

// File: tb/tb_sign_update_ctrl.sv
module tb_sign_update_ctrl;

  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int EW   = 5;
  localparam int NC   = ROWS * COLS;
  localparam int MAXM = (1 << (EW-1)) - 1;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                start;
  logic                mom_clr;
  logic [COLS*EW-1:0]  err_flat;
  logic [ROWS-1:0]     fwd_bits;
  logic [EW-1:0]       sigma;
  logic                cmd_ready;
  logic                cmd_valid;
  logic [1:0]          cmd_row;
  logic [1:0]          cmd_col;
  logic [1:0]          cmd_op;
  logic                busy;
  logic                done;
  logic [4:0]          pulse_count;

  sign_update_ctrl #(.ROWS(ROWS), .COLS(COLS), .EW(EW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mom_clr(mom_clr),
    .err_flat(err_flat), .fwd_bits(fwd_bits), .sigma(sigma),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_op(cmd_op), .busy(busy), .done(done),
    .pulse_count(pulse_count)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int mom_m [COLS];
  int e_in  [COLS];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int qmodel(input int e, input int s);
    int mag, thr;
    mag = (e < 0) ? -e : e;
    if (mag > MAXM) mag = MAXM;
    thr = (s < 0) ? 0 : s;
    if (e == 0) return 0;
    if (mag >= thr) return (e < 0) ? -1 : 1;
    return 0;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // rdy_mode: 0 always ready, 1 pseudo-random, 2 one cycle in three
  task automatic run_iter(input int sig, input logic [ROWS-1:0] fw, input int rdy_mode,
                          input bit disturb, input string req);
    int q [COLS];
    int g [COLS];
    int exp_code [NC];
    int got_code [NC];
    int exp_n, got_n, cyc, mism;
    bit done_seen;
    exp_n = 0; got_n = 0; mism = -1; done_seen = 0;
    for (int c = 0; c < COLS; c++) begin
      q[c] = qmodel(e_in[c], sig);
      g[c] = (q[c] == mom_m[c] && q[c] != 0) ? q[c] : 0;
    end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (fw[r] && g[c] != 0) begin
          exp_code[exp_n] = (r*COLS + c)*4 + ((g[c] > 0) ? 1 : 2);
          exp_n++;
        end
    @(negedge clk);
    for (int c = 0; c < COLS; c++) err_flat[c*EW +: EW] = e_in[c][EW-1:0];
    fwd_bits = fw;
    sigma    = sig[EW-1:0];
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done_seen && cyc < 200) begin
      case (rdy_mode)
        0:       cmd_ready = 1'b1;
        1:       cmd_ready = 1'($urandom % 2);
        default: cmd_ready = (cyc % 3 == 0);
      endcase
      if (disturb && cyc == 2) begin
        start = 1'b1; mom_clr = 1'b1; fwd_bits = ~fw; sigma = '0;   // R7 R11 ignored mid-scan
      end else begin
        start = 1'b0; mom_clr = 1'b0;
      end
      #1;
      if (done) begin
        done_seen = 1;
        chk(int'(pulse_count) == exp_n, "R10", "pulse_count at done", int'(pulse_count), exp_n);
        chk(busy == 1'b0, "R9", "busy with done", int'(busy), 0);
      end else if (cmd_valid && cmd_ready) begin
        if (got_n < NC) got_code[got_n] = (int'(cmd_row)*COLS + int'(cmd_col))*4 + int'(cmd_op);
        got_n++;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; mom_clr = 1'b0; cmd_ready = 1'b1;
    chk(done_seen, "R9", "done seen", int'(done_seen), 1);
    chk(got_n == exp_n, req, "command count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (mism < 0 && got_code[i] != exp_code[i]) mism = i;
    chk(mism < 0, req, "command {cell,op} sequence",
        (mism < 0) ? 0 : got_code[mism], (mism < 0) ? 0 : exp_code[mism]);
    #1;
    chk(done == 1'b0 && busy == 1'b0, "R9", "done one cycle, idle after", int'(done) + 2*int'(busy), 0);
    for (int c = 0; c < COLS; c++) mom_m[c] = q[c];   // R6
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mom_clr = 1'b0; err_flat = '0;
    fwd_bits = '0; sigma = '0; cmd_ready = 1'b1;
    for (int c = 0; c < COLS; c++) begin mom_m[c] = 0; e_in[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(busy == 1'b0, "R12", "busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R12", "done after reset", int'(done), 0);
    chk(cmd_valid == 1'b0, "R12", "cmd_valid after reset", int'(cmd_valid), 0);
    chk(pulse_count == '0, "R12", "pulse_count after reset", int'(pulse_count), 0);

    // R5 first iteration after reset issues nothing
    e_in = '{5, -7, 9, -1};
    run_iter(0, 4'b1111, 0, 0, "R5");

    // R1 R2 R3 sweep of every error against several thresholds, twice each
    foreach (e_in[c]) e_in[c] = 0;
    begin
      int sigs [6] = '{0, 1, 4, 9, 15, -3};
      for (int si = 0; si < 6; si++)
        for (int e = -(MAXM+1); e <= MAXM; e++) begin
          for (int c = 0; c < COLS; c++) e_in[c] = 0;
          e_in[(e + MAXM + 1) % COLS] = e;
          run_iter(sigs[si], 4'b1011, (e + si) % 3, 0, "R1");
          run_iter(sigs[si], 4'b1011, (e + si + 1) % 3, 0, "R2");
        end
    end

    // R3 R4 R8 every forward pattern with mixed signs under back-pressure
    e_in = '{3, -5, 7, -2};
    run_iter(2, 4'b0000, 0, 0, "R6");
    for (int f = 0; f < 16; f++) run_iter(2, 4'(f), f % 3, 0, "R3");
    run_iter(2, 4'b1111, 1, 0, "R4");
    run_iter(2, 4'b0110, 2, 0, "R8");

    // R5 R6 sign flip blocks, then repeated sign updates
    e_in = '{3, 3, 3, 3};
    run_iter(1, 4'b1111, 0, 0, "R6");
    e_in = '{-3, -3, 3, 3};
    run_iter(1, 4'b1111, 0, 0, "R5");
    run_iter(1, 4'b1111, 1, 0, "R6");

    // R7 clear while idle wipes momentum
    @(negedge clk); mom_clr = 1'b1;
    @(negedge clk); mom_clr = 1'b0;
    for (int c = 0; c < COLS; c++) mom_m[c] = 0;
    run_iter(1, 4'b1111, 0, 0, "R7");

    // R7 R11 clear, start and input changes during a scan are ignored
    run_iter(1, 4'b1101, 2, 1, "R11");
    run_iter(1, 4'b1011, 1, 1, "R7");

    finish_run();
  end

endmodule